// File: doc/BRIEF.md
# Flash Sector Protection Write Gate

This block sits between the external strobes of a parallel NOR flash and its internal command logic. It samples chip-select, output-enable, write-enable, the address and the data bus on a system clock. It decides whether a bus cycle is a real write: the strobe polarity must be right, write-enable must stay low long enough, the supply must be above lockout, and no write may be left over from power-up. An accepted write is passed on as a one-clock pulse that carries the address and data held during the low phase of write-enable.

The block also holds one protect bit per sector. A program or erase aimed at a protected sector is flagged as blocked. The bits can only be changed while the reset pin carries high voltage, and that same flag also lifts protection for as long as it is held. A status query, which needs high voltage on address line 9, returns the protect state of the sector on the low data byte.

High-voltage detection, supply lockout and the power-up reset arrive as digital inputs. The protect bits are cleared only by the power-up reset, not by the ordinary reset.

Top module: `flash_wr_gate`

## Requirements
- R1: A write is counted only while ce_n=0, we_n=0 and oe_n=1. oe_n low or ce_n high during the low phase of we_n yields no write pulse.
- R2: we_n must be sampled low, with the other strobes valid, on at least MIN_LOW consecutive clock edges (default 2) before it is sampled high. A shorter low phase gives no write pulse.
- R3: An accepted write appears as wr_pulse high for exactly one clock, in the cycle after the edge that first samples we_n high. wr_addr and wr_data then hold the address and data sampled on the last qualifying low edge.
- R4: While lockout is high, no write pulse is produced and cmd_rst is high. Low-phase edges sampled under lockout do not count toward R2. Protect edits are ignored.
- R5: If ce_n=0, we_n=0 and oe_n=1 are already present when por_n is released, the next rising edge of we_n yields no write pulse.
- R6: After por_n all 128 sectors read as unprotected. The protect bits keep their values through an rst_n reset.
- R7: prot_set sets the bit of sector prot_sec only while rst_hv is high. Without rst_hv the bit is unchanged.
- R8: prot_clr clears the bit of sector prot_sec only while rst_hv is high and every sector is already protected. Otherwise it has no effect. Other sectors keep their bits.
- R9: wr_blocked is high together with wr_pulse when the target sector (address bits 18..12) is protected and rst_hv is low on the edge that accepts the write.
- R10: While rst_hv is high, writes to protected sectors are not blocked. When rst_hv drops, those sectors are blocked again with their bits unchanged.
- R11: A status query (a9_hv=1, ce_n=0, oe_n=0, we_n=1, addr[6]=0, addr[1]=1, addr[0]=0) makes dout_oe high one clock later. dout then holds 01h if the sector in addr[18:12] is protected and 00h if it is not.
- R12: When no status query was sampled on the previous edge, dout_oe is low and dout is 00h.
- R13: cmd_rst is high during any reset and for the first clock after it, which returns the command logic to the read-array state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous; also clears protect bits |
| rst_n | input | 1 | Ordinary reset, active low, asynchronous; protect bits kept |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Write data bus |
| lockout | input | 1 | Supply below write-lockout level |
| rst_hv | input | 1 | High voltage present on the reset pin |
| a9_hv | input | 1 | High voltage present on address line 9 |
| prot_set | input | 1 | Request to protect sector prot_sec |
| prot_clr | input | 1 | Request to unprotect sector prot_sec |
| prot_sec | input | SECT_W | Sector index for protect edits |
| wr_pulse | output | 1 | One-clock qualified write |
| wr_addr | output | ADDR_W | Address of the qualified write |
| wr_data | output | DATA_W | Data of the qualified write |
| wr_blocked | output | 1 | Qualified write targets a locked sector |
| cmd_rst | output | 1 | Resets the command logic to read-array |
| dout | output | DATA_W | Protection status byte |
| dout_oe | output | 1 | Drive enable for dout at the pads |

## Verification
Writes are tried with low phases of one, two and three clocks, which separates the width filter from the capture path. The same write is repeated with output-enable low, with chip-select high, with lockout over the whole cycle, and with lockout over only its first part, which shows whether each gate acts alone and whether lockout clears the width count. Writes to a protected and a free sector, with and without reset-pin high voltage, separate the stored bit from the temporary override. Unprotect requests are issued both before and after every sector is protected, to show the all-protected precondition. Status queries with the address-6 bit set or without address-9 high voltage must leave the output undriven.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

   localparam int unsigned STAT_W      = 8;
   localparam logic [STAT_W-1:0] STAT_LOCKED = 8'h01;
   localparam logic [STAT_W-1:0] STAT_OPEN   = 8'h00;

   // strobe pattern that opens a bus write
   function automatic logic wr_strobes_ok(input logic ce_n, input logic oe_n, input logic we_n);
      return !ce_n && !we_n && oe_n;
   endfunction

   // strobe and address pattern of a protection status query
   function automatic logic rd_query_ok(input logic hv, input logic ce_n, input logic oe_n,
                                        input logic we_n, input logic a6, input logic a1,
                                        input logic a0);
      return hv && !ce_n && !oe_n && we_n && !a6 && a1 && !a0;
   endfunction

endpackage

// File: rtl/fwg_write_qual.sv
module fwg_write_qual
   import fwg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 19,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MIN_LOW = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              lockout,
   input  logic              rst_hv,
   input  logic              tgt_prot,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              wr_pulse,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_blocked,
   output logic              cmd_rst
);

   localparam int unsigned CNT_W = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);

   logic              arst_n;
   logic              strobe_ok;
   logic              hold_ok;
   logic              we_q;
   logic              we_rise;
   logic              armed;
   logic              inh_q;
   logic              rd_rst_q;
   logic              fire;
   logic [ADDR_W-1:0] cap_a_q;
   logic [DATA_W-1:0] cap_d_q;

   assign arst_n    = por_n & rst_n;
   assign strobe_ok = wr_strobes_ok(ce_n, oe_n, we_n);
   assign hold_ok   = strobe_ok & ~lockout;
   assign we_rise   = we_n & ~we_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) we_q <= 1'b1;
      else         we_q <= we_n;
   end

   // width filter: a flag for one clock, a saturating counter otherwise
   generate
      if (MIN_LOW == 1) begin : g_single
         logic seen_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) seen_q <= 1'b0;
            else         seen_q <= hold_ok;
         end
         assign armed = seen_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n)                       cnt_q <= '0;
            else if (!hold_ok)                 cnt_q <= '0;
            else if (cnt_q != CNT_W'(MIN_LOW)) cnt_q <= cnt_q + 1'b1;
         end
         assign armed = (cnt_q == CNT_W'(MIN_LOW));
      end
   endgenerate

   // power-up inhibit: only the power-up reset arms it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) inh_q <= 1'b1;
      else        inh_q <= inh_q & strobe_ok;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) rd_rst_q <= 1'b1;
      else         rd_rst_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cap_a_q <= '0;
         cap_d_q <= '0;
      end else if (hold_ok) begin
         cap_a_q <= addr;
         cap_d_q <= din;
      end
   end

   assign fire = we_rise & armed & ~inh_q & ~lockout;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wr_pulse   <= 1'b0;
         wr_blocked <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
      end else begin
         wr_pulse   <= fire;
         wr_blocked <= fire & tgt_prot & ~rst_hv;
         if (fire) begin
            wr_addr <= cap_a_q;
            wr_data <= cap_d_q;
         end
      end
   end

   assign cap_addr = cap_a_q;
   assign cmd_rst  = lockout | rd_rst_q;

   assert_strobe_pattern_R1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      wr_pulse |-> ($past(we_n) && !$past(we_n, 2) && !$past(ce_n, 2) && $past(oe_n, 2)));

   generate
      if (MIN_LOW >= 2) begin : g_width_chk
         assert_min_low_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
            wr_pulse |-> !$past(we_n, 3));
      end
   endgenerate

   assert_single_clock_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      wr_pulse |=> !wr_pulse);

   assert_lockout_quiet_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      lockout |=> !wr_pulse);

endmodule

// File: rtl/fwg_prot_bank.sv
module fwg_prot_bank #(
   parameter int unsigned SECT_W = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              rst_hv,
   input  logic              lockout,
   input  logic              op_set,
   input  logic              op_clr,
   input  logic [SECT_W-1:0] op_sec,
   input  logic [SECT_W-1:0] look_a,
   input  logic [SECT_W-1:0] look_b,
   output logic              hit_a,
   output logic              hit_b
);

   localparam int unsigned NSECT = 1 << SECT_W;

   logic [NSECT-1:0] bits_q;
   logic             may_edit;
   logic             all_set;

   assign may_edit = rst_n & rst_hv & ~lockout;
   assign all_set  = &bits_q;

   generate
      for (genvar s = 0; s < NSECT; s++) begin : g_sect
         logic sel;
         logic lock_q;
         assign sel = (op_sec == SECT_W'(s));
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)                               lock_q <= 1'b0;
            else if (may_edit & op_set & sel)          lock_q <= 1'b1;
            else if (may_edit & op_clr & all_set & sel) lock_q <= 1'b0;
         end
         assign bits_q[s] = lock_q;
      end
   endgenerate

   assign hit_a = bits_q[look_a];
   assign hit_b = bits_q[look_b];

   assert_edit_needs_hv_R7: assert property (@(posedge clk) disable iff (!por_n)
      (bits_q != $past(bits_q)) |-> ($past(rst_hv) && $past(rst_n) && !$past(lockout)));

   assert_clear_needs_full_R8: assert property (@(posedge clk) disable iff (!por_n)
      ($countones(bits_q) < $countones($past(bits_q))) |-> ($past(bits_q) == '1));

endmodule

// File: rtl/fwg_status.sv
module fwg_status
   import fwg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              a9_hv,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              a6,
   input  logic              a1,
   input  logic              a0,
   input  logic              sect_prot,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   logic arst_n;
   logic query;

   assign arst_n = por_n & rst_n;
   assign query  = rd_query_ok(a9_hv, ce_n, oe_n, we_n, a6, a1, a0);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         dout_oe <= 1'b0;
         dout    <= '0;
      end else begin
         dout_oe <= query;
         if (!query)        dout <= '0;
         else if (sect_prot) dout <= DATA_W'(STAT_LOCKED);
         else               dout <= DATA_W'(STAT_OPEN);
      end
   end

   assert_query_gated_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      dout_oe |-> ($past(a9_hv) && !$past(oe_n) && !$past(ce_n) && $past(we_n)));

endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
   parameter int unsigned ADDR_W  = 19,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned SECT_W  = 7,
   parameter int unsigned MIN_LOW = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              lockout,
   input  logic              rst_hv,
   input  logic              a9_hv,
   input  logic              prot_set,
   input  logic              prot_clr,
   input  logic [SECT_W-1:0] prot_sec,
   output logic              wr_pulse,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_blocked,
   output logic              cmd_rst,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);

   localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

   generate
      if (SECT_LSB < 7) begin : g_bad_addr
         $error("sector field must sit above address bit 6");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("data bus must carry the status byte");
      end
      if (MIN_LOW < 1) begin : g_bad_width
         $error("minimum low width must be at least one clock");
      end
      if (SECT_W < 1 || SECT_W > 10) begin : g_bad_sect
         $error("sector count out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] cap_addr;
   logic              tgt_prot;
   logic              qry_prot;

   fwg_write_qual #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MIN_LOW(MIN_LOW)
   ) u_qual (
      .clk       (clk),
      .por_n     (por_n),
      .rst_n     (rst_n),
      .ce_n      (ce_n),
      .oe_n      (oe_n),
      .we_n      (we_n),
      .addr      (addr),
      .din       (din),
      .lockout   (lockout),
      .rst_hv    (rst_hv),
      .tgt_prot  (tgt_prot),
      .cap_addr  (cap_addr),
      .wr_pulse  (wr_pulse),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_blocked(wr_blocked),
      .cmd_rst   (cmd_rst)
   );

   fwg_prot_bank #(
      .SECT_W(SECT_W)
   ) u_bank (
      .clk    (clk),
      .por_n  (por_n),
      .rst_n  (rst_n),
      .rst_hv (rst_hv),
      .lockout(lockout),
      .op_set (prot_set),
      .op_clr (prot_clr),
      .op_sec (prot_sec),
      .look_a (cap_addr[ADDR_W-1:SECT_LSB]),
      .look_b (addr[ADDR_W-1:SECT_LSB]),
      .hit_a  (tgt_prot),
      .hit_b  (qry_prot)
   );

   fwg_status #(
      .DATA_W(DATA_W)
   ) u_stat (
      .clk      (clk),
      .por_n    (por_n),
      .rst_n    (rst_n),
      .a9_hv    (a9_hv),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .a6       (addr[6]),
      .a1       (addr[1]),
      .a0       (addr[0]),
      .sect_prot(qry_prot),
      .dout     (dout),
      .dout_oe  (dout_oe)
   );

endmodule

// File: tb/tb_flash_wr_gate.sv
module tb_flash_wr_gate;

   localparam int CLK_PER = 10;
   localparam int MINW    = 2;

   logic        clk = 1'b0;
   logic        por_n, rst_n, ce_n, oe_n, we_n;
   logic [18:0] addr;
   logic [7:0]  din;
   logic        lockout, rst_hv, a9_hv, prot_set, prot_clr;
   logic [6:0]  prot_sec;
   logic        wr_pulse, wr_blocked, cmd_rst, dout_oe;
   logic [18:0] wr_addr;
   logic [7:0]  wr_data, dout;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int pulses  = 0;
   int p0;
   bit live    = 0;
   logic [18:0] last_a;
   logic [7:0]  last_d;
   logic        last_b;
   logic [7:0]  rv;
   logic        ro;

   // reference model state
   bit          mp [128];
   int          m_cnt;
   bit          m_weprev, m_inh, m_rdrst, m_pulse, m_blk, m_doe;
   logic [18:0] m_cap_a, m_addr;
   logic [7:0]  m_cap_d, m_data, m_dout;
   bit          t_raw, t_hold, t_rise, t_q, t_all;

   always #(CLK_PER/2) clk = ~clk;

   flash_wr_gate dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .lockout(lockout), .rst_hv(rst_hv), .a9_hv(a9_hv),
      .prot_set(prot_set), .prot_clr(prot_clr), .prot_sec(prot_sec),
      .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .wr_blocked(wr_blocked),
      .cmd_rst(cmd_rst), .dout(dout), .dout_oe(dout_oe)
   );

   task automatic clear_logic();
      m_cnt = 0; m_weprev = 1; m_rdrst = 1; m_pulse = 0; m_blk = 0; m_doe = 0;
      m_dout = 0; m_cap_a = 0; m_cap_d = 0;
   endtask

   always @(posedge clk or negedge por_n or negedge rst_n) begin
      t_raw = !ce_n && !we_n && oe_n;
      if (!por_n) begin
         foreach (mp[i]) mp[i] = 0;
         m_inh = 1;
         clear_logic();
      end else if (!rst_n) begin
         m_inh = m_inh && t_raw;
         clear_logic();
      end else begin
         t_hold  = t_raw && !lockout;
         t_rise  = we_n && !m_weprev;
         m_pulse = t_rise && (m_cnt >= MINW) && !m_inh && !lockout;
         if (m_pulse) begin m_addr = m_cap_a; m_data = m_cap_d; end
         m_blk  = m_pulse && mp[m_cap_a[18:12]] && !rst_hv;
         t_q    = a9_hv && !ce_n && !oe_n && we_n && !addr[6] && addr[1] && !addr[0];
         m_doe  = t_q;
         m_dout = (t_q && mp[addr[18:12]]) ? 8'h01 : 8'h00;
         if (t_hold) begin
            m_cnt   = (m_cnt < MINW) ? m_cnt + 1 : MINW;
            m_cap_a = addr;
            m_cap_d = din;
         end else m_cnt = 0;
         m_weprev = we_n;
         m_inh    = m_inh && t_raw;
         m_rdrst  = 0;
         t_all = 1;
         foreach (mp[i]) if (!mp[i]) t_all = 0;
         if (rst_hv && !lockout) begin
            if (prot_set) mp[prot_sec] = 1;
            else if (prot_clr && t_all) mp[prot_sec] = 0;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (por_n && rst_n && live) begin
         chk("R3 wr_pulse", wr_pulse, m_pulse);
         if (m_pulse) begin
            chk("R3 wr_addr", wr_addr, m_addr);
            chk("R3 wr_data", wr_data, m_data);
         end
         chk("R9 wr_blocked", wr_blocked, m_blk);
         chk("R4 cmd_rst", cmd_rst, lockout | m_rdrst);
         chk("R11 dout_oe", dout_oe, m_doe);
         chk("R12 dout", dout, m_dout);
      end
      if (wr_pulse) begin
         pulses++; last_a = wr_addr; last_d = wr_data; last_b = wr_blocked;
      end
   end

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         summary();
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #(CLK_PER/4);
   endtask

   task automatic idle();
      ce_n = 1; oe_n = 1; we_n = 1; a9_hv = 0; prot_set = 0; prot_clr = 0;
   endtask

   function automatic logic [18:0] sa(input int s, input logic [11:0] lo);
      return {s[6:0], lo};
   endfunction

   task automatic wr(input logic [18:0] a, input logic [7:0] d, input int n,
                     input logic oev, input logic cev);
      ce_n = cev; oe_n = oev; addr = a; din = d; we_n = 0;
      repeat (n) step();
      we_n = 1;
      step();
      idle();
      step(); step();
   endtask

   task automatic rd(input int s, input logic a6v, input logic a9v,
                     output logic [7:0] v, output logic o);
      a9_hv = a9v; ce_n = 0; oe_n = 0; we_n = 1;
      addr = {s[6:0], 5'b0, a6v, 4'b0, 1'b1, 1'b0};
      step();
      v = dout; o = dout_oe;
      idle();
      step();
   endtask

   task automatic prot(input bit set, input int s);
      prot_sec = s[6:0]; prot_set = set; prot_clr = !set;
      step();
      prot_set = 0; prot_clr = 0;
   endtask

   initial begin
      por_n = 0; rst_n = 1; ce_n = 0; oe_n = 1; we_n = 0; addr = '0; din = '0;
      lockout = 0; rst_hv = 0; a9_hv = 0; prot_set = 0; prot_clr = 0; prot_sec = '0;
      repeat (3) step();
      chk("R12 dout_oe low in reset", dout_oe, 0);
      chk("R13 cmd_rst in reset", cmd_rst, 1);
      por_n = 1; live = 1;
      #1;
      chk("R13 cmd_rst first clock after power-up", cmd_rst, 1);
      // R5: write strobes already active at power-up
      step(); step();
      we_n = 1;
      step(); idle(); step(); step();
      chk("R5 power-up write not accepted", pulses, 0);
      chk("R13 cmd_rst released", cmd_rst, 0);

      wr(sa(3, 12'h0A5), 8'h5C, 3, 1, 0);
      chk("R3 one pulse", pulses, 1);
      chk("R3 captured address", last_a, sa(3, 12'h0A5));
      chk("R3 captured data", last_d, 8'h5C);

      p0 = pulses;
      wr(sa(4, 12'h010), 8'h11, 1, 1, 0);
      chk("R2 one-clock low rejected", pulses, p0);
      wr(sa(4, 12'h020), 8'h22, 2, 1, 0);
      chk("R2 minimum width accepted", pulses, p0 + 1);
      chk("R3 data at minimum width", last_d, 8'h22);

      p0 = pulses;
      wr(sa(7, 12'h001), 8'h33, 3, 0, 0);
      chk("R1 output-enable low blocks", pulses, p0);
      wr(sa(7, 12'h002), 8'h44, 3, 1, 1);
      chk("R1 chip-select high blocks", pulses, p0);

      // R4: lockout
      lockout = 1;
      #1 chk("R4 cmd_rst under lockout", cmd_rst, 1);
      wr(sa(8, 12'h003), 8'h55, 3, 1, 0);
      chk("R4 write ignored under lockout", pulses, p0);
      rst_hv = 1;
      prot(1, 9);
      rst_hv = 0; lockout = 0;
      rd(9, 0, 1, rv, ro);
      chk("R4 protect edit ignored under lockout", rv, 8'h00);
      ce_n = 0; oe_n = 1; we_n = 0; addr = sa(8, 12'h004); din = 8'h66; lockout = 1;
      step(); step();
      lockout = 0;
      step();
      we_n = 1;
      step(); idle(); step(); step();
      chk("R4 low edges under lockout not counted", pulses, p0);

      // R7 / R11
      prot(1, 5);
      rd(5, 0, 1, rv, ro);
      chk("R7 set ignored without rst_hv", rv, 8'h00);
      rst_hv = 1; prot(1, 5); rst_hv = 0;
      rd(5, 0, 1, rv, ro);
      chk("R7 set with rst_hv", rv, 8'h01);
      chk("R11 dout_oe on query", ro, 1);

      // R9
      wr(sa(5, 12'h100), 8'h77, 2, 1, 0);
      chk("R9 protected sector blocked", last_b, 1);
      wr(sa(6, 12'h100), 8'h78, 2, 1, 0);
      chk("R9 free sector not blocked", last_b, 0);

      // R10
      p0 = pulses;
      rst_hv = 1;
      wr(sa(5, 12'h200), 8'h79, 2, 1, 0);
      chk("R10 temporary unprotect passes write", pulses, p0 + 1);
      chk("R10 not blocked with rst_hv", last_b, 0);
      rst_hv = 0;
      rd(5, 0, 1, rv, ro);
      chk("R10 bit kept after rst_hv drops", rv, 8'h01);
      wr(sa(5, 12'h300), 8'h7A, 2, 1, 0);
      chk("R10 blocked again", last_b, 1);

      // R6: ordinary reset keeps bits
      rst_n = 0; step(); step(); rst_n = 1; step();
      rd(5, 0, 1, rv, ro);
      chk("R6 bit kept over rst_n", rv, 8'h01);

      // R8
      rst_hv = 1; prot(0, 5); rst_hv = 0;
      rd(5, 0, 1, rv, ro);
      chk("R8 clear refused while sectors open", rv, 8'h01);
      rst_hv = 1;
      for (int s = 0; s < 128; s++) prot(1, s);
      prot(0, 5);
      prot(0, 6);
      rst_hv = 0;
      rd(5, 0, 1, rv, ro);
      chk("R8 clear after all protected", rv, 8'h00);
      rd(6, 0, 1, rv, ro);
      chk("R8 second clear refused", rv, 8'h01);
      rd(7, 0, 1, rv, ro);
      chk("R8 other sector kept", rv, 8'h01);

      // R11 / R12 negative queries
      rd(6, 1, 1, rv, ro);
      chk("R11 addr6 high no query", ro, 0);
      chk("R12 dout zero without query", rv, 8'h00);
      rd(6, 0, 0, rv, ro);
      chk("R11 no a9 high voltage no query", ro, 0);

      // R6: power-up reset clears bits
      por_n = 0; step(); por_n = 1; step(); step();
      rd(6, 0, 1, rv, ro);
      chk("R6 cleared by power-up", rv, 8'h00);

      summary();
      $finish;
   end

endmodule